// File: doc/BRIEF.md
# Dual Signed Multiplier Slice with Pre-Adders

The slice holds two independent signed multipliers, a top half and a bottom half. Each half forms a 37-bit product from an 18-bit operand and a 19-bit operand. A build parameter can place a pre-adder in front of the 19-bit operand. The pre-adder sums that operand with an 18-bit secondary input. A second build parameter can replace the 18-bit live operand with one of eight constants, which a 3-bit select picks at run time.

The top half can take its 19-bit operand from either of two sources, chosen by a run-time control bit. One is its direct input. The other is the low part of a 27-bit cascade word. The slice registers the cascade word and drives it out again, so that neighbouring slices can form a chain with one cycle of delay per slice.

Each half has an input register stage and an output register stage. The slice has one clock, three active-high enables (input stage, output stage, cascade register) and two active-high clears (input stage plus cascade, output stage). A parameter selects whether the clears act synchronously or asynchronously. An active-low asynchronous reset clears every register.

Top module: `dual_mult_slice`

## Requirements
- R1: With all enables high and no clear, res_a_o equals the signed product of the top 18-bit operand and the top 19-bit operand, two clock edges after the inputs are presented.
- R2: res_b_o equals the signed product bx_i × by_i, with the same latency as R1 and independent of all top-half inputs.
- R3: With PREADD_EN=1, the 19-bit operand of each half is y + sign-extended z, wrapped to 19 bits with no saturation. With PREADD_EN=0, the z inputs have no effect on the results.
- R4: With COEF_EN=1, the 18-bit operand of each half is coefficient k of that half, where k is the 3-bit select value (0 to 7). Coefficient k sits in bits [18k+17:18k] of the COEF_A or COEF_B parameter.
- R5: When top_direct_i=1, the top 19-bit operand is ay_i. When top_direct_i=0, it is cas_i[18:0].
- R6: When ena_i[2]=1 and clr_i[0]=0, cas_o takes the value of cas_i on the next clock edge. When clr_i[0]=1 and ena_i[2]=1, cas_o becomes zero.
- R7: A register stage whose enable is low holds its value. This applies to the input stage (ena_i[0]), the output stage (ena_i[1]) and the cascade register (ena_i[2]).
- R8: With CLR_ASYNC=0, a clear zeroes its stage on a clock edge only while that stage's enable is high. A clear that is asserted while the enable is low has no effect.
- R9: With CLR_ASYNC=1, a high clr_i[1] forces both results to zero at once, with no clock edge and regardless of the enables.
- R10: While rst_ni is low, both results and cas_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for all registers |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ena_i | input | 3 | Enables: [0] input stage, [1] output stage, [2] cascade register |
| clr_i | input | 2 | Clears: [0] input stage and cascade register, [1] output stage |
| ax_i | input | 18 | Top 18-bit operand (unused when coefficients are enabled) |
| ay_i | input | 19 | Top 19-bit operand, direct source |
| az_i | input | 18 | Top pre-adder addend |
| bx_i | input | 18 | Bottom 18-bit operand (unused when coefficients are enabled) |
| by_i | input | 19 | Bottom 19-bit operand |
| bz_i | input | 18 | Bottom pre-adder addend |
| sel_a_i | input | 3 | Top coefficient select |
| sel_b_i | input | 3 | Bottom coefficient select |
| top_direct_i | input | 1 | 1: top operand from ay_i; 0: from cas_i[18:0] |
| cas_i | input | 27 | Cascade word from the previous slice |
| cas_o | output | 27 | Registered cascade word to the next slice |
| res_a_o | output | 37 | Top signed product |
| res_b_o | output | 37 | Bottom signed product |

## Verification
The hardest case to reach from the ports is an enable that is low while a clear is high. In that case the synchronous variant must ignore the clear and the asynchronous variant must obey it. The bench drives the same stimulus into two instances, one with synchronous clears and one with asynchronous clears, and compares their results in the same cycle. Pre-adder wrap-around is reached with the same method. The sweep pairs extreme 19-bit values with extreme 18-bit addends, so that the sum leaves the 19-bit range, and the asynchronous instance also has the pre-adder enabled.

// File: rtl/dmul_pkg.sv
package dmul_pkg;
  localparam int unsigned X_W_DEF   = 18;
  localparam int unsigned Y_W_DEF   = 19;
  localparam int unsigned Z_W_DEF   = 18;
  localparam int unsigned CAS_W_DEF = 27;
  localparam int unsigned NCOEF_DEF = 8;
  localparam int unsigned NHALF     = 2;

  typedef enum logic [0:0] {HALF_TOP = 1'b0, HALF_BOT = 1'b1} half_e;
endpackage

// File: rtl/dmul_reg.sv
module dmul_reg #(
  parameter int unsigned W         = 8,
  parameter bit          CLR_ASYNC = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (CLR_ASYNC) begin : g_aclr
      always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
        if (!rst_ni)     q_o <= '0;
        else if (clr_i)  q_o <= '0;
        else if (en_i)   q_o <= d_i;
      end
    end else begin : g_sclr
      // enable gates the clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q_o <= '0;
        else if (en_i)   q_o <= clr_i ? '0 : d_i;
      end
    end
  endgenerate
endmodule

// File: rtl/dmul_half.sv
module dmul_half #(
  parameter int unsigned X_W       = 18,
  parameter int unsigned Y_W       = 19,
  parameter int unsigned Z_W       = 18,
  parameter int unsigned NCOEF     = 8,
  parameter bit          PREADD_EN = 1'b0,
  parameter bit          COEF_EN   = 1'b0,
  parameter bit          CLR_ASYNC = 1'b0,
  parameter logic [NCOEF*X_W-1:0] COEF = '0,
  localparam int unsigned SEL_W = $clog2(NCOEF),
  localparam int unsigned P_W   = X_W + Y_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_in_i,
  input  logic             clr_in_i,
  input  logic             en_out_i,
  input  logic             clr_out_i,
  input  logic [X_W-1:0]   x_i,
  input  logic [Y_W-1:0]   y_i,
  input  logic [Z_W-1:0]   z_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [P_W-1:0]   res_o
);
  logic [X_W-1:0] x_pick, x_q;
  logic [Y_W-1:0] y_q, y_eff;
  logic [P_W-1:0] prod;

  generate
    if (COEF_EN) begin : g_coef
      wire unused_x = ^x_i;
      assign x_pick = COEF[sel_i*X_W +: X_W];
    end else begin : g_live
      wire unused_sel = ^sel_i;
      assign x_pick = x_i;
    end
  endgenerate

  dmul_reg #(.W(X_W), .CLR_ASYNC(CLR_ASYNC)) u_xr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_in_i), .clr_i(clr_in_i),
    .d_i(x_pick), .q_o(x_q));

  dmul_reg #(.W(Y_W), .CLR_ASYNC(CLR_ASYNC)) u_yr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_in_i), .clr_i(clr_in_i),
    .d_i(y_i), .q_o(y_q));

  generate
    if (PREADD_EN) begin : g_pre
      logic [Z_W-1:0] z_q;
      dmul_reg #(.W(Z_W), .CLR_ASYNC(CLR_ASYNC)) u_zr (
        .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_in_i), .clr_i(clr_in_i),
        .d_i(z_i), .q_o(z_q));
      // wrap, no saturation
      assign y_eff = y_q + {{(Y_W-Z_W){z_q[Z_W-1]}}, z_q};
    end else begin : g_nopre
      wire unused_z = ^z_i;
      assign y_eff = y_q;
    end
  endgenerate

  always_comb begin
    prod = $signed({{Y_W{x_q[X_W-1]}}, x_q}) * $signed({{X_W{y_eff[Y_W-1]}}, y_eff});
  end

  dmul_reg #(.W(P_W), .CLR_ASYNC(CLR_ASYNC)) u_pr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_out_i), .clr_i(clr_out_i),
    .d_i(prod), .q_o(res_o));
endmodule

// File: rtl/dual_mult_slice.sv
module dual_mult_slice
  import dmul_pkg::*;
#(
  parameter int unsigned X_W       = X_W_DEF,
  parameter int unsigned Y_W       = Y_W_DEF,
  parameter int unsigned Z_W       = Z_W_DEF,
  parameter int unsigned CAS_W     = CAS_W_DEF,
  parameter int unsigned NCOEF     = NCOEF_DEF,
  parameter bit          PREADD_EN = 1'b0,
  parameter bit          COEF_EN   = 1'b0,
  parameter bit          CLR_ASYNC = 1'b0,
  parameter logic [NCOEF*X_W-1:0] COEF_A = '0,
  parameter logic [NCOEF*X_W-1:0] COEF_B = '0,
  localparam int unsigned SEL_W = $clog2(NCOEF),
  localparam int unsigned P_W   = X_W + Y_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       ena_i,
  input  logic [1:0]       clr_i,
  input  logic [X_W-1:0]   ax_i,
  input  logic [Y_W-1:0]   ay_i,
  input  logic [Z_W-1:0]   az_i,
  input  logic [X_W-1:0]   bx_i,
  input  logic [Y_W-1:0]   by_i,
  input  logic [Z_W-1:0]   bz_i,
  input  logic [SEL_W-1:0] sel_a_i,
  input  logic [SEL_W-1:0] sel_b_i,
  input  logic             top_direct_i,
  input  logic [CAS_W-1:0] cas_i,
  output logic [CAS_W-1:0] cas_o,
  output logic [P_W-1:0]   res_a_o,
  output logic [P_W-1:0]   res_b_o
);
  logic [X_W-1:0]   x_v   [NHALF];
  logic [Y_W-1:0]   y_v   [NHALF];
  logic [Z_W-1:0]   z_v   [NHALF];
  logic [SEL_W-1:0] sel_v [NHALF];
  logic [P_W-1:0]   res_v [NHALF];

  always_comb begin
    x_v[HALF_TOP]   = ax_i;
    y_v[HALF_TOP]   = top_direct_i ? ay_i : cas_i[Y_W-1:0];
    z_v[HALF_TOP]   = az_i;
    sel_v[HALF_TOP] = sel_a_i;
    x_v[HALF_BOT]   = bx_i;
    y_v[HALF_BOT]   = by_i;
    z_v[HALF_BOT]   = bz_i;
    sel_v[HALF_BOT] = sel_b_i;
  end

  generate
    for (genvar g = 0; g < NHALF; g++) begin : g_half
      dmul_half #(
        .X_W(X_W), .Y_W(Y_W), .Z_W(Z_W), .NCOEF(NCOEF),
        .PREADD_EN(PREADD_EN), .COEF_EN(COEF_EN), .CLR_ASYNC(CLR_ASYNC),
        .COEF((g == 0) ? COEF_A : COEF_B)
      ) u_half (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .en_in_i(ena_i[0]), .clr_in_i(clr_i[0]),
        .en_out_i(ena_i[1]), .clr_out_i(clr_i[1]),
        .x_i(x_v[g]), .y_i(y_v[g]), .z_i(z_v[g]), .sel_i(sel_v[g]),
        .res_o(res_v[g]));
    end
  endgenerate

  assign res_a_o = res_v[HALF_TOP];
  assign res_b_o = res_v[HALF_BOT];

  // one cycle per slice in the chain
  dmul_reg #(.W(CAS_W), .CLR_ASYNC(CLR_ASYNC)) u_cas (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ena_i[2]), .clr_i(clr_i[0]),
    .d_i(cas_i), .q_o(cas_o));
endmodule

// File: rtl/dual_mult_slice_chk.sv
module dual_mult_slice_chk #(
  parameter int unsigned CAS_W     = 27,
  parameter int unsigned P_W       = 37,
  parameter bit          CLR_ASYNC = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       ena_i,
  input logic [1:0]       clr_i,
  input logic [CAS_W-1:0] cas_i,
  input logic [CAS_W-1:0] cas_o,
  input logic [P_W-1:0]   res_a_o,
  input logic [P_W-1:0]   res_b_o
);
  a_r10_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (res_a_o == '0 && res_b_o == '0 && cas_o == '0));

  a_r6_cas_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena_i[2] && !clr_i[0]) |=> (clr_i[0] || cas_o == $past(cas_i)));

  a_r7_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ena_i[1] && !clr_i[1]) |=> (clr_i[1] || ($stable(res_a_o) && $stable(res_b_o))));

  a_r7_cas_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ena_i[2] && !clr_i[0]) |=> (clr_i[0] || $stable(cas_o)));

  generate
    if (CLR_ASYNC) begin : g_a
      a_r9_async_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i[1] |-> (res_a_o == '0 && res_b_o == '0));
    end else begin : g_s
      a_r8_sync_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ena_i[1] && clr_i[1]) |=> (res_a_o == '0 && res_b_o == '0));
      a_r8_clear_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ena_i[1] |=> ($stable(res_a_o) && $stable(res_b_o)));
    end
  endgenerate
endmodule

bind dual_mult_slice dual_mult_slice_chk #(
  .CAS_W(CAS_W), .P_W(P_W), .CLR_ASYNC(CLR_ASYNC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ena_i(ena_i), .clr_i(clr_i),
  .cas_i(cas_i), .cas_o(cas_o), .res_a_o(res_a_o), .res_b_o(res_b_o));

// File: tb/sim_dual_mult_slice.sv
`timescale 1ns/1ps
module sim_dual_mult_slice;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [2:0] ena;
  logic [1:0] clr;
  logic [17:0] ax, az, bx, bz;
  logic [18:0] ay, by;
  logic [2:0] sa, sb;
  logic top_direct;
  logic [26:0] cas_in;
  logic [26:0] cas0, cas1;
  logic [36:0] ra0, rb0, ra1, rb1;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  function automatic longint ca(int i);
    case (i)
      0: return 0;        1: return 1;
      2: return -1;       3: return 131071;
      4: return -131072;  5: return 12345;
      6: return -777;     default: return 4096;
    endcase
  endfunction
  function automatic longint cb(int i); return ca(7 - i); endfunction

  localparam logic [143:0] CA_P = {18'(4096), 18'(-777), 18'(12345), 18'(-131072),
                                   18'(131071), 18'(-1), 18'(1), 18'(0)};
  localparam logic [143:0] CB_P = {18'(0), 18'(1), 18'(-1), 18'(131071),
                                   18'(-131072), 18'(12345), 18'(-777), 18'(4096)};

  dual_mult_slice u0 (
    .clk_i(clk), .rst_ni(rst_n), .ena_i(ena), .clr_i(clr),
    .ax_i(ax), .ay_i(ay), .az_i(az), .bx_i(bx), .by_i(by), .bz_i(bz),
    .sel_a_i(sa), .sel_b_i(sb), .top_direct_i(top_direct), .cas_i(cas_in),
    .cas_o(cas0), .res_a_o(ra0), .res_b_o(rb0));

  dual_mult_slice #(.PREADD_EN(1'b1), .COEF_EN(1'b1), .CLR_ASYNC(1'b1),
                    .COEF_A(CA_P), .COEF_B(CB_P)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .ena_i(ena), .clr_i(clr),
    .ax_i(ax), .ay_i(ay), .az_i(az), .bx_i(bx), .by_i(by), .bz_i(bz),
    .sel_a_i(sa), .sel_b_i(sb), .top_direct_i(top_direct), .cas_i(cas_in),
    .cas_o(cas1), .res_a_o(ra1), .res_b_o(rb1));

  task automatic chk(string req, longint act, longint exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint s37(logic [36:0] v); return longint'($signed(v)); endfunction
  function automatic longint wrap19(longint v);
    logic [18:0] t;
    t = v[18:0];
    return longint'($signed(t));
  endfunction

  task automatic check_all(string tag);
    longint yt, ea0, eb0, ea1, eb1;
    logic [18:0] cl;
    cl = cas_in[18:0];
    yt = top_direct ? longint'($signed(ay)) : longint'($signed(cl));
    ea0 = longint'($signed(ax)) * yt;
    eb0 = longint'($signed(bx)) * longint'($signed(by));
    ea1 = ca(int'(sa)) * wrap19(yt + longint'($signed(az)));
    eb1 = cb(int'(sb)) * wrap19(longint'($signed(by)) + longint'($signed(bz)));
    chk({"R1 ", tag}, s37(ra0), ea0);
    chk({"R2 ", tag}, s37(rb0), eb0);
    chk({"R3 R4 top ", tag}, s37(ra1), ea1);
    chk({"R3 R4 bottom ", tag}, s37(rb1), eb1);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  int xs[8] = '{-131072, -1, 0, 1, 131071, 77777, -5000, 3};
  int ys[8] = '{-262144, -1, 0, 1, 262143, 200001, -99999, 12};
  int zs[4] = '{-131072, 0, 131071, -1};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [36:0] h_a0, h_b0, h_a1, h_b1;
    logic [26:0] h_c;
    ena = 3'b111; clr = 2'b00; top_direct = 1'b1;
    ax = '0; ay = '0; az = '0; bx = '0; by = '0; bz = '0; sa = '0; sb = '0;
    cas_in = 27'h5A5A5A5;
    #1 rst_n = 1'b0;
    step(3);
    // R10
    chk("R10 res_a", s37(ra0) | s37(ra1), 0);
    chk("R10 res_b", s37(rb0) | s37(rb1), 0);
    chk("R10 cas", longint'(cas0 | cas1), 0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 sweep; z varied with u0 shows z ignored without pre-adder (R3)
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int k = 0; k < 4; k++) begin
          ax = 18'(xs[i]); bx = 18'(xs[7-i]);
          ay = 19'(ys[j]); by = 19'(ys[7-j]);
          az = 18'(zs[k]); bz = 18'(zs[3-k]);
          sa = 3'(i); sb = 3'(j);
          step(2);
          check_all("sweep");
        end

    // R5 cascade-fed top operand
    top_direct = 1'b0;
    for (int j = 0; j < 8; j++) begin
      cas_in = {8'hC3 ^ 8'(j), 19'(ys[j])};
      ax = 18'(xs[j]); ay = 19'(ys[7-j]);
      step(2);
      check_all("R5 cascade");
    end
    top_direct = 1'b1;

    // R6 cascade forward
    cas_in = 27'h7FFFFFF;
    step(1);
    chk("R6 cas u0", longint'(cas0), longint'(27'h7FFFFFF));
    chk("R6 cas u1", longint'(cas1), longint'(27'h7FFFFFF));
    cas_in = 27'h0123456;
    step(1);
    chk("R6 cas next", longint'(cas0), longint'(27'h0123456));

    // R7 cascade hold
    ena[2] = 1'b0; cas_in = 27'h1555555;
    step(2);
    chk("R7 cas hold", longint'(cas0), longint'(27'h0123456));
    ena[2] = 1'b1;

    // R7 input-stage hold
    ax = 18'(1234); ay = 19'(-4321); bx = 18'(-9); by = 19'(77); az = 18'(5); bz = 18'(-6);
    sa = 3'd5; sb = 3'd6;
    step(2);
    check_all("R7 baseline");
    h_a0 = ra0; h_b0 = rb0; h_a1 = ra1; h_b1 = rb1;
    ena = 3'b110;
    ax = 18'(999); ay = 19'(999); bx = 18'(999); by = 19'(999); sa = 3'd3; sb = 3'd3;
    step(2);
    chk("R7 in hold a0", s37(ra0), s37(h_a0));
    chk("R7 in hold b1", s37(rb1), s37(h_b1));
    // R7 output-stage hold
    ena = 3'b101;
    step(2);
    chk("R7 out hold a0", s37(ra0), s37(h_a0));
    chk("R7 out hold a1", s37(ra1), s37(h_a1));
    ena = 3'b111;
    step(1);
    check_all("R7 release");

    // R8 clear ignored while disabled (u0); R9 async clear (u1)
    h_a0 = ra0; h_b0 = rb0;
    ena = 3'b101; clr = 2'b10;
    #1;
    chk("R9 async a1", s37(ra1), 0);
    chk("R9 async b1", s37(rb1), 0);
    step(1);
    chk("R8 gated a0", s37(ra0), s37(h_a0));
    chk("R8 gated b0", s37(rb0), s37(h_b0));
    ena = 3'b111;
    step(1);
    chk("R8 sync clr a0", s37(ra0), 0);
    chk("R8 sync clr b0", s37(rb0), 0);
    clr = 2'b00;
    step(1);
    check_all("R8 after clear");

    // R8 R6 input-stage clear zeroes operands and cascade
    h_c = cas0;
    ena = 3'b011; clr = 2'b01;
    step(1);
    chk("R8 cas gated", longint'(cas0), longint'(h_c));
    ena = 3'b111;
    step(1);
    chk("R6 cas clear", longint'(cas0), 0);
    clr = 2'b00; ena = 3'b110;
    step(1);
    chk("R8 in clr a0", s37(ra0), 0);
    chk("R8 in clr a1", s37(ra1), 0);
    chk("R8 in clr b1", s37(rb1), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule